// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls a port of seven general-purpose pins through a byte-wide register bus. The bus has an address, write data, a write strobe and combinational read data. Each pin has three control bits. A direction bit makes the pin an input or an output. A polarity bit inverts both the value seen on the input path and the value driven on the output path. An output-style bit selects whether the pin holds a steady level or emits one pulse of fixed length each time a 1 is written to it. The pad is driven through separate output-enable and output-value signals, so the tri-state buffer itself sits outside the block.

Live pin levels reach software through a synchroniser of two flops and an inversion stage. They appear in a read-only input register. A second read-only register captures the raw pin levels while reset is held low, but only when a strap-enable input is high. The bottom three bits of that captured value are also driven out as a bus-address strap.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Reset values, read back at the listed addresses, are: output data (0x09) = 0x00, polarity (0x0A) = 0x70, direction (0x0B) = 0x7F, output style (0x0C) = 0x00. After reset, `pin_oe_o` is all zero.
- R2: Writes with `we_i` high take effect at the next clock edge. They store bits 6..0 of `wdata_i` into output data (0x09), polarity (0x0A), direction (0x0B) or output style (0x0C). Bit 7 of every register reads as 0.
- R3: Any address other than 0x08..0x0D reads 0x00, and this includes 0x0E and 0x0F. A write to such an address changes no register and no pin output.
- R4: Direction bit value 1 makes the pin an input (`pin_oe_o` bit = 0). Value 0 makes it an output (`pin_oe_o` bit = 1), from the cycle after the write.
- R5: `pin_out_o` bit = stored output bit XOR polarity bit.
- R6: Reading 0x08 returns each pin level delayed by two clocks and XORed with its polarity bit, whatever the pin's direction.
- R7: Reading 0x09 returns the stored output bits, not the pin levels.
- R8: When a pin's style bit is 1 and its stored output bit is 1, the stored bit stays 1 for exactly PULSE_CYCLES clocks and then clears by itself. Writing 1 again while the pulse runs does not restart it.
- R9: When a pin's style bit is 0, its stored output bit keeps its value until it is written again.
- R10: While `rst_ni` is low and `strap_en_i` is high, each clock edge copies the raw pins into the strap register (0x0D). While `strap_en_i` is low, a reset leaves the strap register unchanged. `strap_addr_o` = strap bits 2..0.
- R11: Registers 0x08 and 0x0D are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 7 | Pad input levels |
| pin_oe_o | output | 7 | Pad output enable, 1 = drive |
| pin_out_o | output | 7 | Pad output value |
| strap_en_i | input | 1 | Enables strap capture during reset |
| strap_addr_o | output | 3 | Bus address taken from strap bits 2..0 |

## Verification
The bench builds the block with seven pins and PULSE_CYCLES set to 5. This shortens pulses so that a full pulse, the self-clear and a rewrite in the middle of a pulse all fit into a few clocks. The synchroniser keeps its default depth of two, so the bench model checks the two-clock delay of the input path exactly. Three separate resets, given with the strap enable high, then low, then high, exercise both the capture and the hold of the strap register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_IN    = 8'h08;
  localparam logic [REG_AW-1:0] ADDR_OUT   = 8'h09;
  localparam logic [REG_AW-1:0] ADDR_POL   = 8'h0A;
  localparam logic [REG_AW-1:0] ADDR_DIR   = 8'h0B;
  localparam logic [REG_AW-1:0] ADDR_STYLE = 8'h0C;
  localparam logic [REG_AW-1:0] ADDR_STRAP = 8'h0D;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pulse.sv
module gpio_pulse #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = arm_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!arm_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/gpio_strap.sv
module gpio_strap #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] strap_o
);
  logic [WIDTH-1:0] strap_q;

  // no reset: the value must survive reset when capture is disabled
  always_ff @(posedge clk_i) begin
    if (!rst_ni && en_i) strap_q <= pin_i;
  end

  assign strap_o = strap_q;

  // R10
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(strap_q));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 7,
  parameter int unsigned PULSE_CYCLES = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BUS_ADDR_W   = 3,
  parameter logic [NUM_PINS-1:0] POL_RST = 7'h70
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [REG_DW-1:0]     wdata_i,
  input  logic                  we_i,
  output logic [REG_DW-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   pin_out_o,
  input  logic                  strap_en_i,
  output logic [BUS_ADDR_W-1:0] strap_addr_o
);
  localparam int unsigned PAD_W = REG_DW - NUM_PINS;

  logic [NUM_PINS-1:0] out_q, pol_q, dir_q, style_q;
  logic [NUM_PINS-1:0] pin_sync, strap_val, expire;
  logic [NUM_PINS-1:0] wbits;

  assign wbits = wdata_i[NUM_PINS-1:0];

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_strap #(.WIDTH(NUM_PINS)) u_strap (
    .clk_i, .rst_ni, .en_i(strap_en_i), .pin_i, .strap_o(strap_val)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pulse
    gpio_pulse #(.CYCLES(PULSE_CYCLES)) u_pulse (
      .clk_i, .rst_ni,
      .arm_i(style_q[i] & out_q[i]),
      .expire_o(expire[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      pol_q   <= POL_RST;
      dir_q   <= '1;
      style_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_OUT) out_q <= wbits;
      else                            out_q <= out_q & ~expire;
      if (we_i && addr_i == ADDR_POL)   pol_q   <= wbits;
      if (we_i && addr_i == ADDR_DIR)   dir_q   <= wbits;
      if (we_i && addr_i == ADDR_STYLE) style_q <= wbits;
    end
  end

  assign pin_oe_o     = ~dir_q;
  assign pin_out_o    = out_q ^ pol_q;
  assign strap_addr_o = strap_val[BUS_ADDR_W-1:0];

  always_comb begin
    logic [NUM_PINS-1:0] sel;
    unique case (addr_i)
      ADDR_IN:    sel = pin_sync ^ pol_q;
      ADDR_OUT:   sel = out_q;
      ADDR_POL:   sel = pol_q;
      ADDR_DIR:   sel = dir_q;
      ADDR_STYLE: sel = style_q;
      ADDR_STRAP: sel = strap_val;
      default:    sel = '0;
    endcase
    rdata_o = {{PAD_W{1'b0}}, sel};
  end

  // R4
  oe_after_dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIR) |=> (pin_oe_o == ~$past(wbits)));

  // R3
  reserved_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i < ADDR_IN || addr_i > ADDR_STRAP)) |=>
      ($stable(pin_oe_o) && $stable(pol_q) && $stable(style_q)));

  // R8
  pulse_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire && !(we_i && addr_i == ADDR_OUT)) |=> ((out_q & $past(expire)) == '0));

  // R11
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == ADDR_IN || addr_i == ADDR_STRAP)) |=>
      ($stable(dir_q) && $stable(pol_q) && $stable(style_q)));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int P = 5;
  localparam int N = 7;

  logic       clk = 0, rst_n = 0, we = 0, strap_en = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic [6:0] pins = 7'h5A;
  logic [7:0] rdata;
  logic [6:0] oe, pout;
  logic [2:0] saddr;

  gpio_port_ctrl #(.PULSE_CYCLES(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pin_i(pins), .pin_oe_o(oe), .pin_out_o(pout),
    .strap_en_i(strap_en), .strap_addr_o(saddr)
  );

  always #10 clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  bit done = 0, strap_ok = 0;

  // reference model
  bit [6:0] m_out, m_pol, m_dir, m_sty, m_s1, m_s2, m_strap;
  int m_age [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_pol = 7'h70; m_dir = 7'h7F; m_sty = 0; m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < N; i++) m_age[i] = 0;
    end else begin
      bit [6:0] nx;
      nx = m_out;
      for (int i = 0; i < N; i++) begin
        if (m_sty[i] && m_out[i]) begin
          if (m_age[i] == P-1) nx[i] = 0;
          else m_age[i]++;
        end else m_age[i] = 0;
      end
      if (we) begin
        case (addr)
          8'h09: nx = wdata[6:0];
          8'h0A: m_pol = wdata[6:0];
          8'h0B: m_dir = wdata[6:0];
          8'h0C: m_sty = wdata[6:0];
          default: ;
        endcase
      end
      m_out = nx;
      m_s2 = m_s1; m_s1 = pins;
    end
  end

  always @(posedge clk) if (!rst_n && strap_en) begin m_strap = pins; strap_ok = 1; end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h08: return {1'b0, m_s2 ^ m_pol};
      8'h09: return {1'b0, m_out};
      8'h0A: return {1'b0, m_pol};
      8'h0B: return {1'b0, m_dir};
      8'h0C: return {1'b0, m_sty};
      8'h0D: return {1'b0, m_strap};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      8'h08: return "R6";
      8'h09: return "R7";
      8'h0A, 8'h0B, 8'h0C: return "R2";
      8'h0D: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({1'b0, oe}, {1'b0, ~m_dir}, "R4");
      chk({1'b0, pout}, {1'b0, m_out ^ m_pol}, "R5/R8/R9");
      if (addr != 8'h0D || strap_ok) chk(rdata, exp_rd(addr), rd_tag(addr));
      if (strap_ok) chk({5'b0, saddr}, {5'b0, m_strap[2:0]}, "R10");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failed++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic step(logic [7:0] a, logic [7:0] d, logic w);
    @(negedge clk); #2;
    addr = a; wdata = d; we = w;
  endtask

  task automatic rd(logic [7:0] a); step(a, 8'h00, 0); endtask
  task automatic wr(logic [7:0] a, logic [7:0] d); step(a, d, 1); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) rd(addr); endtask

  task automatic do_reset(logic en, logic [6:0] p);
    @(negedge clk); #2;
    rst_n = 0; strap_en = en; pins = p; we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2; rst_n = 1;
    // R1 reset values
    rd(8'h09); rd(8'h0A); rd(8'h0B); rd(8'h0C);
    @(negedge clk); chk(rdata, 8'h00, "R1 style");
    chk({1'b0, oe}, 8'h00, "R1 oe");
    // R10 strap captured at first reset (0x5A, address 2)
    rd(8'h0D); @(negedge clk); chk(rdata, 8'h5A, "R10 strap"); chk({5'b0, saddr}, 8'h02, "R10 addr");
    for (int a = 0; a < 20; a++) rd(a[7:0]);
    // R2/R4/R5 outputs
    wr(8'h0B, 8'h80); wr(8'h09, 8'hAB); rd(8'h09);
    @(negedge clk); chk(rdata, 8'h2B, "R2 bit7");
    wr(8'h0A, 8'h0F); rd(8'h0A); wr(8'h0B, 8'hF0); rd(8'h0B);
    // R6/R7 input path independent of direction
    for (int k = 0; k < 8; k++) begin
      step(8'h08, 0, 0); pins = 7'(k * 37 + 3);
      rd(8'h08); rd(8'h09); rd(8'h08);
    end
    // R3 reserved, R11 read-only
    wr(8'h0E, 8'hFF); wr(8'h0F, 8'hFF); wr(8'h20, 8'hFF); wr(8'h08, 8'hFF); wr(8'h0D, 8'hFF);
    rd(8'h0D); @(negedge clk); chk(rdata, 8'h5A, "R11 strap ro");
    rd(8'h0E); @(negedge clk); chk(rdata, 8'h00, "R3 reserved");
    // R8 pulse mode on bits 0 and 2, R9 level on bit 1
    wr(8'h0A, 8'h00); wr(8'h09, 8'h00); wr(8'h0C, 8'h05); wr(8'h09, 8'h07);
    rd(8'h09); idle(P + 3);
    @(negedge clk); chk(rdata, 8'h02, "R8 self-clear / R9 level held");
    wr(8'h09, 8'h01); idle(2); wr(8'h09, 8'h01); idle(P + 2);
    @(negedge clk); chk(rdata, 8'h00, "R8 no restart");
    wr(8'h0A, 8'h7F); wr(8'h09, 8'h04); idle(P + 2);
    wr(8'h0C, 8'h00); wr(8'h09, 8'h04); idle(12);
    @(negedge clk); chk(rdata, 8'h04, "R9 level");
    // R10 strap hold with enable low, capture with enable high
    do_reset(0, 7'h11); rd(8'h0D); @(negedge clk); chk(rdata, 8'h5A, "R10 hold");
    do_reset(1, 7'h13); rd(8'h0D); @(negedge clk); chk(rdata, 8'h13, "R10 recapture");
    chk({5'b0, saddr}, 8'h03, "R10 addr");
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule